// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

The sequencer sits on the controller side of an asynchronous dynamic memory and turns one host request into one complete memory cycle. A request carries a word address, a per-byte enable, write data and a direction flag. The sequencer places the upper half of the address on a shared half-width address bus and lowers the row strobe. After a programmable delay it places the lower half on the same bus and lowers the column strobe of each enabled byte lane. It holds the row strobe low for at least a minimum active time. It then keeps the row strobe high for a programmable precharge gap before it accepts the next request.

Requests arrive through a valid/ready handshake from an external arbiter, which also owns refresh and start-up sequencing. Each request ends with a one-cycle response pulse. For reads, the pulse carries the sampled data with the bytes that were not enabled forced to zero. Every delay is a parameter counted in clock cycles.

Top module: `mxdram_sequencer`

## Requirements
- R1: After reset, the row strobe, both column strobes, the write strobe and the output-enable strobe are high (inactive), no data lane is driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: When the row strobe falls, `dram_a` holds address bits [17:9]. When a column strobe falls, `dram_a` holds address bits [8:0].
- R3: The first column strobe falls exactly `T_RCD` cycles after the row strobe falls.
- R4: The row strobe stays low for exactly max(`T_RAS`, `T_RCD`+`T_CAS`) cycles. The column strobes are low for `T_CAS` cycles and are all high again no later than the row strobe rises.
- R5: Between two cycles the row strobe stays high for at least `T_RP` cycles. `req_ready` is 0 whenever the row strobe is low. If a request is already waiting, the next row strobe falls after exactly `T_RP` high cycles.
- R6: `dram_cas_n[0]` (bits 7:0) goes low only if `req_be[0]` was 1, and `dram_cas_n[1]` (bits 15:8) goes low only if `req_be[1]` was 1. A write to one lane leaves the other byte of the stored word unchanged.
- R7: For a write, the write strobe is low for the whole time the row strobe is low. Only the enabled lanes are driven with the write data, from the row strobe fall onward. The output-enable strobe stays high.
- R8: For a read, the write strobe stays high and the output-enable strobe is low while the column strobes are low. For every request, `rsp_valid` pulses for one cycle, `T_RCD`+`T_CAS` cycles after the accepting edge. On a read, `rsp_rdata` carries the bus data sampled at the end of the column phase, with the lanes that were not enabled read as zero.
- R9: A request with both byte enables 0 lowers no column strobe and changes no stored data. It still runs the full row timing and produces its response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row half [17:9], column half [8:0] |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_a | output | 9 | Multiplexed address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output-enable strobe, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_oe | output | 2 | Per-lane drive enable |
| dram_dq_in | input | 16 | Data returned from the memory |

## Verification
The hardest case to reach from the ports is a row strobe whose low time is set by `T_RAS` and not by the column phase. The bench overrides the delays so that `T_RAS` exceeds `T_RCD`+`T_CAS`, which forces the hold phase to run. A second hard case is the exact precharge gap, which only appears when the next request is already waiting before ready returns. A dedicated task raises the next request right after the response pulse of the previous one. The bench's memory model drives a fixed filler byte on lanes whose strobe is not low, so a read that leaks a disabled lane shows up as a wrong value.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROW,
    PH_COL,
    PH_HOLD,
    PH_PRE
  } phase_t;

  // Row-strobe low time: the longer of the minimum active time and the
  // row-to-column delay plus the column phase.
  function automatic int act_len(input int t_ras, input int t_rcd, input int t_cas);
    return (t_rcd + t_cas > t_ras) ? (t_rcd + t_cas) : t_ras;
  endfunction

endpackage

// File: rtl/mxd_timer.sv
module mxd_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/mxd_lane_gate.sv
module mxd_lane_gate #(
  parameter int NL = 2
) (
  input  logic [NL-1:0]   be,
  input  logic [NL*8-1:0] bus_in,
  output logic [NL-1:0]   strobe_sel,
  output logic [NL*8-1:0] data_masked
);
  assign strobe_sel = be;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign data_masked[l*8 +: 8] = be[l] ? bus_in[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/mxdram_sequencer.sv
module mxdram_sequencer #(
  parameter int AW    = 18,
  parameter int DW    = 16,
  parameter int T_RCD = 3,
  parameter int T_CAS = 3,
  parameter int T_RAS = 5,
  parameter int T_RP  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW/8-1:0]    req_be,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic [AW/2-1:0]    dram_a,
  output logic               dram_ras_n,
  output logic [DW/8-1:0]    dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_oe_n,
  output logic [DW-1:0]      dram_dq_out,
  output logic [DW/8-1:0]    dram_dq_oe,
  input  logic [DW-1:0]      dram_dq_in
);
  import mxd_pkg::*;

  localparam int HW     = AW / 2;
  localparam int NL     = DW / 8;
  localparam int T_ACT  = act_len(T_RAS, T_RCD, T_CAS);
  localparam int T_HOLD = T_ACT - T_RCD - T_CAS;
  localparam int TW     = $clog2(T_ACT + T_RP + 2);

  phase_t        ph, ph_nx;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;

  logic [HW-1:0] col_q;
  logic [NL-1:0] be_q;
  logic          write_q;
  logic [NL-1:0] lane_strobe;
  logic [DW-1:0] rd_masked;

  // Named events, also watched by the checker.
  logic accept, cas_fire, cas_end, ras_end;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign cas_fire  = (ph == PH_ROW) && tmr_done;
  assign cas_end   = (ph == PH_COL) && tmr_done;
  assign ras_end   = tmr_done && ((ph == PH_HOLD) || ((ph == PH_COL) && (T_HOLD == 0)));

  mxd_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  mxd_lane_gate #(.NL(NL)) u_lanes (
    .be          (be_q),
    .bus_in      (dram_dq_in),
    .strobe_sel  (lane_strobe),
    .data_masked (rd_masked)
  );

  // Phase sequencing; each phase is loaded with its length minus one.
  always_comb begin
    ph_nx    = ph;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph)
      PH_IDLE: if (accept) begin
        ph_nx = PH_ROW; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
      end
      PH_ROW: if (tmr_done) begin
        ph_nx = PH_COL; tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1);
      end
      PH_COL: if (tmr_done) begin
        if (T_HOLD > 0) begin
          ph_nx = PH_HOLD; tmr_load = 1'b1; tmr_val = TW'(T_HOLD - 1);
        end else if (T_RP > 1) begin
          ph_nx = PH_PRE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 2);
        end else begin
          ph_nx = PH_IDLE;
        end
      end
      PH_HOLD: if (tmr_done) begin
        if (T_RP > 1) begin
          ph_nx = PH_PRE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 2);
        end else begin
          ph_nx = PH_IDLE;
        end
      end
      PH_PRE: if (tmr_done) ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= '1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= '0;
      dram_dq_out <= '0;
      dram_a      <= '0;
      col_q       <= '0;
      be_q        <= '0;
      write_q     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      ph        <= ph_nx;
      rsp_valid <= cas_end;
      if (accept) begin
        dram_ras_n <= 1'b0;
        dram_a     <= req_addr[AW-1:HW];
        col_q      <= req_addr[HW-1:0];
        be_q       <= req_be;
        write_q    <= req_write;
        dram_we_n  <= ~req_write;
        if (req_write) begin
          dram_dq_out <= req_wdata;
          dram_dq_oe  <= req_be;
        end
      end
      if (cas_fire) begin
        dram_a     <= col_q;
        dram_cas_n <= ~lane_strobe;
        dram_oe_n  <= write_q;
      end
      if (cas_end) begin
        dram_cas_n <= '1;
        dram_oe_n  <= 1'b1;
        if (!write_q) rsp_rdata <= rd_masked;
      end
      if (ras_end) begin
        dram_ras_n <= 1'b1;
        dram_we_n  <= 1'b1;
        dram_dq_oe <= '0;
      end
    end
  end
endmodule

// File: rtl/mxd_checker.sv
module mxd_checker #(
  parameter int NL    = 2,
  parameter int T_RCD = 3,
  parameter int T_CAS = 3,
  parameter int T_RAS = 5,
  parameter int T_RP  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          ras_n,
  input logic [NL-1:0] cas_n,
  input logic          we_n,
  input logic [NL-1:0] be_q,
  input logic          rsp_valid,
  input logic          cas_fire
);
  logic        ras_prev;
  logic        seen;
  logic [15:0] low_cnt, high_cnt;
  logic        ras_fall, ras_rise;

  assign ras_fall = ras_prev && !ras_n;
  assign ras_rise = !ras_prev && ras_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      seen     <= 1'b0;
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      ras_prev <= ras_n;
      if (ras_fall) seen <= 1'b1;
      if (!ras_n) begin
        high_cnt <= '0;
        if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
        if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 1'b1;
      end
    end
  end

  assert_precharge_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && seen) |-> (int'(high_cnt) >= T_RP));

  assert_busy_while_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !req_ready);

  assert_min_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise |-> (int'(low_cnt) >= T_RAS));

  assert_cas_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise |-> (&cas_n));

  assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cas_n) |-> !ras_n);

  assert_row_to_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fire |-> (int'(low_cnt) == T_RCD - 1));

  assert_lane_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cas_n) & (~be_q)) == '0);

  assert_we_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !ras_prev) |-> $stable(we_n));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind mxdram_sequencer mxd_checker #(
  .NL(DW/8), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .be_q      (be_q),
  .rsp_valid (rsp_valid),
  .cas_fire  (cas_fire)
);

// File: tb/mxdram_sequencer_test.sv
`timescale 1ns/1ps
module mxdram_sequencer_test;
  localparam int P_RCD = 2;
  localparam int P_CAS = 2;
  localparam int P_RAS = 6;
  localparam int P_RP  = 3;
  localparam int P_ACT = (P_RCD + P_CAS > P_RAS) ? P_RCD + P_CAS : P_RAS;
  localparam int P_LAT = P_RCD + P_CAS + 1;   // negedges counted from the one after acceptance

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0]  dram_a;
  logic        dram_ras_n, dram_we_n, dram_oe_n;
  logic [1:0]  dram_cas_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mxdram_sequencer #(
    .T_RCD(P_RCD), .T_CAS(P_CAS), .T_RAS(P_RAS), .T_RP(P_RP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  // Memory model and strobe monitor, sampled on the falling clock edge.
  logic [15:0] mem [1024];
  logic [8:0]  row_cap, col_cap;
  logic        ras_prev_m = 1'b1;
  logic [1:0]  cas_prev_m = 2'b11;
  int          lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0, rcd_seen = 0;
  logic [1:0]  cas_mask, cas_union, oe_at_cas;
  logic        we_at_cas, oe_at_cas_rd, oe_low_seen, ready_viol;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    row_cap = '0; col_cap = '0; cas_mask = '0; cas_union = '0; oe_at_cas = '0;
    we_at_cas = 1'b1; oe_at_cas_rd = 1'b1; oe_low_seen = 1'b0; ready_viol = 1'b0;
  end

  always_comb begin
    for (int l = 0; l < 2; l++)
      dram_dq_in[l*8 +: 8] = (!dram_oe_n && !dram_cas_n[l])
                             ? mem[{row_cap[4:0], dram_a[4:0]}][l*8 +: 8] : 8'hEE;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_ras_n && ras_prev_m) begin
        last_hi = hi_run; hi_run = 0; lo_run = 1;
        row_cap = dram_a; cas_union = '0; oe_low_seen = 1'b0;
      end else if (!dram_ras_n) lo_run++;
      if (dram_ras_n && !ras_prev_m) begin
        last_lo = lo_run; lo_run = 0; hi_run = 1;
      end else if (dram_ras_n) hi_run++;
      if (dram_cas_n != 2'b11 && cas_prev_m == 2'b11) begin
        rcd_seen = lo_run - 1; col_cap = dram_a; cas_mask = ~dram_cas_n;
        we_at_cas = dram_we_n; oe_at_cas = dram_dq_oe; oe_at_cas_rd = dram_oe_n;
      end
      cas_union = cas_union | ~dram_cas_n;
      if (!dram_oe_n) oe_low_seen = 1'b1;
      if (!dram_ras_n && req_ready) ready_viol = 1'b1;
      for (int l = 0; l < 2; l++)
        if (!dram_ras_n && !dram_cas_n[l] && !dram_we_n && dram_dq_oe[l])
          mem[{row_cap[4:0], dram_a[4:0]}][l*8 +: 8] = dram_dq_out[l*8 +: 8];
      ras_prev_m = dram_ras_n;
      cas_prev_m = dram_cas_n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #0.5;
  endtask

  // One request; returns read data and response latency in negedges.
  task automatic do_req(input bit wr, input logic [17:0] ad, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_be = be; req_wdata = wd;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin tick(); lat++; end
    rd = rsp_rdata;
  endtask

  task automatic wait_ras_high();
    int n = 0;
    while (!dram_ras_n && n < 100) begin tick(); n++; end
  endtask

  task automatic t_reset();
    check(dram_ras_n == 1'b1, "R1 ras_n", dram_ras_n, 1);
    check(dram_cas_n == 2'b11, "R1 cas_n", dram_cas_n, 3);
    check(dram_we_n && dram_oe_n, "R1 we_n/oe_n", {dram_we_n, dram_oe_n}, 3);
    check(dram_dq_oe == 2'b00, "R1 dq_oe", dram_dq_oe, 0);
    check(req_ready && !rsp_valid, "R1 ready/rsp", {req_ready, rsp_valid}, 2);
  endtask

  task automatic t_full_word();
    logic [15:0] rd; int lat;
    do_req(1'b1, 18'h12345, 2'b11, 16'hBEEF, rd, lat);
    check(lat == P_LAT, "R8 write latency", lat, P_LAT);
    check(row_cap == 9'(18'h12345 >> 9), "R2 row half", row_cap, 9'(18'h12345 >> 9));
    check(col_cap == 9'(18'h12345), "R2 col half", col_cap, 9'(18'h12345));
    check(rcd_seen == P_RCD, "R3 row-to-col", rcd_seen, P_RCD);
    check(we_at_cas == 1'b0, "R7 we at cas", we_at_cas, 0);
    check(oe_at_cas == 2'b11, "R7 lanes driven", oe_at_cas, 3);
    wait_ras_high();
    check(last_lo == P_ACT, "R4 ras low time", last_lo, P_ACT);
    check(!oe_low_seen, "R7 oe high on write", oe_low_seen, 0);
    do_req(1'b0, 18'h12345, 2'b11, 16'h0000, rd, lat);
    check(rd == 16'hBEEF, "R8 read data", rd, 16'hBEEF);
    check(lat == P_LAT, "R8 read latency", lat, P_LAT);
    check(we_at_cas == 1'b1 && oe_at_cas_rd == 1'b0, "R8 we/oe on read",
          {we_at_cas, oe_at_cas_rd}, 2);
    wait_ras_high();
  endtask

  task automatic t_byte_lanes();
    logic [15:0] rd; int lat;
    do_req(1'b1, 18'h12345, 2'b01, 16'h77AA, rd, lat);
    check(cas_union == 2'b01, "R6 lower strobe only", cas_union, 1);
    check(oe_at_cas == 2'b01, "R7 lower lane driven", oe_at_cas, 1);
    wait_ras_high();
    do_req(1'b0, 18'h12345, 2'b11, 16'h0000, rd, lat);
    check(rd == 16'hBEAA, "R6 merged byte write", rd, 16'hBEAA);
    wait_ras_high();
    do_req(1'b0, 18'h12345, 2'b10, 16'h0000, rd, lat);
    check(cas_union == 2'b10, "R6 upper strobe only", cas_union, 2);
    check(rd == 16'hBE00, "R8 disabled lane zero", rd, 16'hBE00);
    wait_ras_high();
  endtask

  task automatic t_no_lanes();
    logic [15:0] rd; int lat;
    do_req(1'b1, 18'h12345, 2'b00, 16'h1234, rd, lat);
    check(lat == P_LAT, "R9 response without lanes", lat, P_LAT);
    check(cas_union == 2'b00, "R9 no column strobe", cas_union, 0);
    wait_ras_high();
    check(last_lo == P_ACT, "R9 full row timing", last_lo, P_ACT);
    do_req(1'b0, 18'h12345, 2'b11, 16'h0000, rd, lat);
    check(rd == 16'hBEAA, "R9 data unchanged", rd, 16'hBEAA);
    wait_ras_high();
  endtask

  task automatic t_back_to_back();
    logic [15:0] rd; int lat;
    do_req(1'b1, 18'h3FE01, 2'b11, 16'h5A3C, rd, lat);
    check(row_cap == 9'h1FF && col_cap == 9'h001, "R2 second address",
          {row_cap, col_cap}, {9'h1FF, 9'h001});
    do_req(1'b0, 18'h3FE01, 2'b11, 16'h0000, rd, lat);
    check(last_hi == P_RP, "R5 exact precharge gap", last_hi, P_RP);
    check(rd == 16'h5A3C, "R8 back-to-back read", rd, 16'h5A3C);
    wait_ras_high();
    check(!ready_viol, "R5 ready low while active", ready_viol, 0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_full_word();
    t_byte_lanes();
    t_no_lanes();
    t_back_to_back();
    repeat (4) tick();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule